// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the byte-level control engine of an I2C master. Software programs a control word (enable, master, direction, repeat mode, stop and start requests), a byte count and a target address through a small register port. The sequencer then drives a byte-command PHY with START (address phase), WRITE, READ and STOP commands. Each command is a valid/done handshake that returns an acknowledge result. Payload bytes come from an attached transmit buffer, and bytes read from the bus go into an attached receive buffer. Both buffers report their fill level to the sequencer.

A transfer runs in one of two ways. In counted mode the remaining count drops by one for each byte moved. When it reaches zero, the sequencer either closes the bus with a STOP or flags access-ready and drops the master bit. In repeat mode the count is ignored, and the transfer ends only when a stop request is present at an evaluation. After it has gone idle while the bus is held, the sequencer looks at the buffers again only when the buffer owner pulses `data_kick` after a host data access. A NACK cancels any pending stop. The bit-timing settings are stored here and passed unchanged to the PHY.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control (address 0) keeps only the bits in mask 0xCF07. Bit 15 is enable, 14 is byte order, 10 is master, 9 is transmit (1 = write to target), 8 is 10-bit addressing, 2 is repeat mode, 1 is stop request and 0 is start request. It reads back what was stored.
- R2: Writing control with bit 15 clear returns every register, the remaining count and the status to zero in the next cycle, and returns the sequencer to idle with the bus released.
- R3: With enable and master set, 10-bit addressing clear and the start bit set, the sequencer issues START (code 0) with the target register (address 2, lower 10 bits kept) and the read flag equal to the inverse of the transmit bit. The start bit reads 0 once the command has completed.
- R4: A NACK on START sets status bit 0, clears the stop bit, leaves the bus released (status bit 2 = 0) and issues no further command.
- R5: In counted transmit the sequencer issues WRITE (code 1) with the head byte of the transmit buffer while both the remaining count and the buffer level are non-zero. Each completed byte pops the buffer and decrements the remaining count, and address 1 reads back the remaining count.
- R6: When the count is exhausted with the stop bit set, STOP (code 3) is issued. The stop bit then clears, the remaining count reloads from the programmed value and the bus is released.
- R7: When the count is exhausted with the stop bit clear, status bit 1 (access-ready) is set, control bit 10 clears and no STOP is issued.
- R8: In counted receive the sequencer issues READ (code 2) while the count is non-zero and the receive buffer holds fewer than BUF_DEPTH bytes. Each returned byte is pushed into the buffer unchanged.
- R9: In repeat mode the count is neither checked nor changed. Transmit drains the whole buffer, and a stop request present at an evaluation issues STOP at once.
- R10: A NACK on a WRITE stops the sending, sets status bit 0, clears the stop bit and keeps the bus held.
- R11: While the bus is held and the sequencer waits, no command is issued until `data_kick` is pulsed.
- R12: With the master bit clear or 10-bit addressing set, a start request issues no command.
- R13: Only one command is outstanding at a time: valid and the command code stay unchanged until done.
- R14: Prescaler (address 3), clock-low (address 4) and clock-high (address 5) read back as written and drive their PHY outputs unchanged. Status (address 6) has bit 0 NACK, bit 1 access-ready and bit 2 bus-held. Writing 1 to bit 0 or bit 1 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| data_kick | input | 1 | Pulse after a host data-buffer access; triggers re-evaluation |
| tx_level | input | LVL_W | Bytes held in the transmit buffer |
| tx_data | input | 8 | Head byte of the transmit buffer |
| tx_pop | output | 1 | Remove the head transmit byte |
| rx_level | input | LVL_W | Bytes held in the receive buffer |
| rx_data | output | 8 | Byte to push into the receive buffer |
| rx_push | output | 1 | Push rx_data into the receive buffer |
| phy_cmd_valid | output | 1 | Command request to the PHY |
| phy_cmd | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| phy_addr | output | ADDR_W | Target address for START |
| phy_read | output | 1 | Read flag for START and READ |
| phy_wdata | output | 8 | Byte for WRITE |
| phy_done | input | 1 | Command completed |
| phy_nack | input | 1 | Acknowledge missing, valid with phy_done |
| phy_rdata | input | 8 | Byte returned by READ, valid with phy_done |
| cfg_prescale | output | TIM_W | Prescaler setting for the PHY |
| cfg_scl_low | output | TIM_W | Clock-low setting for the PHY |
| cfg_scl_high | output | TIM_W | Clock-high setting for the PHY |

## Verification
The assertions watch, on every cycle, the rules that can be read off one or two edges. These are the command handshake holding steady, no pop from an empty transmit buffer or push into a full receive buffer, no count decrement at zero, the reload after a stop, the stop bit dropping after a NACK, silence while waiting without a kick, and no START without master mode. Only the bench scenarios can show the full command order of a transfer. That covers how many bytes a counted transfer moves before it splits across kicks, that repeat mode really ignores the count, what the remaining-count and status registers read after each phase, and that a soft reset wipes the whole register set.

// File: rtl/i2cs_pkg.sv
// Package: shared constants and types of the I2C transfer sequencer.
// Assumes a 16-bit register port and a byte-wide PHY.
package i2cs_pkg;

    localparam int REG_W = 16;

    // Control bit positions
    localparam int CTL_EN  = 15;
    localparam int CTL_MST = 10;
    localparam int CTL_TRX = 9;
    localparam int CTL_XA  = 8;
    localparam int CTL_RM  = 2;
    localparam int CTL_STP = 1;
    localparam int CTL_STT = 0;
    localparam logic [REG_W-1:0] CTL_WMASK = 16'hCF07;

    // Register addresses
    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_COUNT  = 3'd1;
    localparam logic [2:0] RA_TARGET = 3'd2;
    localparam logic [2:0] RA_PRESC  = 3'd3;
    localparam logic [2:0] RA_SCLLO  = 3'd4;
    localparam logic [2:0] RA_SCLHI  = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd6;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } phy_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_EVAL,
        S_SEND,
        S_RECV,
        S_STOP,
        S_WAIT
    } seq_state_e;

endpackage

// File: rtl/i2cs_regs.sv
// Register set: control, programmed count, target, timing and status.
// The sequencer's clear and set pulses change control and status bits. A host
// write to control in the same cycle takes precedence over the sequencer's clears.
// Writing control with enable clear wipes every register (soft reset).
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10,
    parameter int TIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  cnt_cur,
    input  logic              busy,
    input  logic              clr_stt,
    input  logic              clr_stp,
    input  logic              clr_mst,
    input  logic              set_nack,
    input  logic              set_ardy,
    output logic              soft_rst,
    output logic              ctl_wr,
    output logic [REG_W-1:0]  ctl_q,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic [ADDR_W-1:0] target,
    output logic [TIM_W-1:0]  presc,
    output logic [TIM_W-1:0]  scl_lo,
    output logic [TIM_W-1:0]  scl_hi
);

    logic nack_q;
    logic ardy_q;
    logic st_w1c;

    // Decode host writes that need special handling.
    always_comb begin
        ctl_wr   = reg_wr && (reg_addr == RA_CTRL);
        soft_rst = ctl_wr && !reg_wdata[CTL_EN];
        st_w1c   = reg_wr && (reg_addr == RA_STATUS);
    end

    // Store the configuration registers and apply the sequencer's bit updates.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctl_q    <= '0;
            prog_cnt <= '0;
            target   <= '0;
            presc    <= '0;
            scl_lo   <= '0;
            scl_hi   <= '0;
            nack_q   <= 1'b0;
            ardy_q   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= reg_wdata & CTL_WMASK;
            end else begin
                if (clr_stt) ctl_q[CTL_STT] <= 1'b0;
                if (clr_stp) ctl_q[CTL_STP] <= 1'b0;
                if (clr_mst) ctl_q[CTL_MST] <= 1'b0;
            end
            if (reg_wr && reg_addr == RA_COUNT)  prog_cnt <= reg_wdata[CNT_W-1:0];
            if (reg_wr && reg_addr == RA_TARGET) target   <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == RA_PRESC)  presc    <= reg_wdata[TIM_W-1:0];
            if (reg_wr && reg_addr == RA_SCLLO)  scl_lo   <= reg_wdata[TIM_W-1:0];
            if (reg_wr && reg_addr == RA_SCLHI)  scl_hi   <= reg_wdata[TIM_W-1:0];
            nack_q <= set_nack || (nack_q && !(st_w1c && reg_wdata[0]));
            ardy_q <= set_ardy || (ardy_q && !(st_w1c && reg_wdata[1]));
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = ctl_q;
            RA_COUNT:  reg_rdata = REG_W'(cnt_cur);
            RA_TARGET: reg_rdata = REG_W'(target);
            RA_PRESC:  reg_rdata = REG_W'(presc);
            RA_SCLLO:  reg_rdata = REG_W'(scl_lo);
            RA_SCLHI:  reg_rdata = REG_W'(scl_hi);
            RA_STATUS: reg_rdata = {{(REG_W-3){1'b0}}, busy, ardy_q, nack_q};
            default:   reg_rdata = '0;
        endcase
    end

    // R1: no bit outside the write mask ever becomes set in control
    p_ctl_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_WMASK) == '0);

    // R2: a soft reset leaves every register and status bit at zero
    p_soft_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctl_q == '0) && (prog_cnt == '0) && (target == '0)
                     && !nack_q && !ardy_q);

endmodule

// File: rtl/i2cs_count.sv
// Remaining-count register: reloads from the programmed count, or counts down.
// Assumes the sequencer never asks for a decrement at zero.
module i2cs_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] prog_cnt,
    output logic [CNT_W-1:0] cnt_cur,
    output logic             cnt_zero
);

    // Hold the remaining count: reload has priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt_cur <= '0;
        end else if (load) begin
            cnt_cur <= prog_cnt;
        end else if (dec) begin
            cnt_cur <= cnt_cur - 1'b1;
        end
    end

    // Flag the exhausted count for the sequencer.
    always_comb cnt_zero = (cnt_cur == '0);

    // R5: the count never wraps below zero
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_cur != '0));

    // R6: a reload makes the remaining count equal to the programmed count
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !soft_rst) |=> (cnt_cur == $past(prog_cnt)));

endmodule

// File: rtl/i2cs_fsm.sv
// Transfer sequencer FSM: issues one PHY command at a time and, between
// commands, decides in the EVAL state what to do next. This covers counted
// versus repeat mode, transmit versus receive, stop and access-ready.
// It assumes the PHY holds done for exactly one cycle per command, and that
// control is not rewritten while a command is outstanding.
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int BUF_DEPTH = 4,
    parameter int LVL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_wr,
    input  logic             kick,
    input  logic             c_en,
    input  logic             c_mst,
    input  logic             c_xa,
    input  logic             c_trx,
    input  logic             c_rm,
    input  logic             c_stp,
    input  logic             c_stt,
    input  logic             cnt_zero,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             phy_done,
    input  logic             phy_nack,
    output logic             phy_cmd_valid,
    output logic [1:0]       phy_cmd,
    output logic             phy_read,
    output logic             tx_pop,
    output logic             rx_push,
    output logic             cnt_load,
    output logic             cnt_dec,
    output logic             clr_stt,
    output logic             clr_stp,
    output logic             clr_mst,
    output logic             set_nack,
    output logic             set_ardy,
    output logic             busy
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(BUF_DEPTH);

    seq_state_e state_q, state_d;
    logic       busy_set, busy_clr;
    logic       tx_avail, rx_room, start_ok;

    // Summarise the buffer and start conditions.
    always_comb begin
        tx_avail = (tx_level != '0);
        rx_room  = (rx_level < FULL_LVL);
        start_ok = c_en && c_mst && !c_xa && c_stt;
    end

    // Drive the PHY request from the current state.
    always_comb begin
        phy_cmd_valid = 1'b0;
        phy_cmd       = CMD_START;
        phy_read      = 1'b0;
        case (state_q)
            S_START: begin phy_cmd_valid = 1'b1; phy_cmd = CMD_START; phy_read = !c_trx; end
            S_SEND:  begin phy_cmd_valid = 1'b1; phy_cmd = CMD_WRITE; end
            S_RECV:  begin phy_cmd_valid = 1'b1; phy_cmd = CMD_READ;  phy_read = 1'b1; end
            S_STOP:  begin phy_cmd_valid = 1'b1; phy_cmd = CMD_STOP;  end
            default: ;
        endcase
    end

    // Choose the next state and the side-effect pulses.
    always_comb begin
        state_d  = state_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        clr_stt  = 1'b0;
        clr_stp  = 1'b0;
        clr_mst  = 1'b0;
        set_nack = 1'b0;
        set_ardy = 1'b0;
        busy_set = 1'b0;
        busy_clr = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start_ok) state_d = S_START;
            end
            S_START: begin
                if (phy_done) begin
                    clr_stt = 1'b1;
                    if (phy_nack) begin
                        set_nack = 1'b1;
                        clr_stp  = 1'b1;
                        state_d  = S_IDLE;
                    end else begin
                        busy_set = 1'b1;
                        cnt_load = 1'b1;
                        state_d  = S_EVAL;
                    end
                end
            end
            S_EVAL: begin
                if (c_rm) begin
                    if (c_stp)              state_d = S_STOP;
                    else if (c_trx)         state_d = tx_avail ? S_SEND : S_WAIT;
                    else                    state_d = rx_room ? S_RECV : S_WAIT;
                end else if (cnt_zero) begin
                    if (c_stp) begin
                        state_d = S_STOP;
                    end else begin
                        set_ardy = 1'b1;
                        clr_mst  = 1'b1;
                        state_d  = S_WAIT;
                    end
                end else if (c_trx) begin
                    state_d = tx_avail ? S_SEND : S_WAIT;
                end else begin
                    state_d = rx_room ? S_RECV : S_WAIT;
                end
            end
            S_SEND: begin
                if (phy_done) begin
                    tx_pop  = 1'b1;
                    cnt_dec = !c_rm;
                    if (phy_nack) begin
                        set_nack = 1'b1;
                        clr_stp  = 1'b1;
                        state_d  = S_WAIT;
                    end else begin
                        state_d  = S_EVAL;
                    end
                end
            end
            S_RECV: begin
                if (phy_done) begin
                    rx_push = 1'b1;
                    cnt_dec = !c_rm;
                    state_d = S_EVAL;
                end
            end
            S_STOP: begin
                if (phy_done) begin
                    clr_stp  = 1'b1;
                    cnt_load = 1'b1;
                    busy_clr = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_WAIT: begin
                if (kick) state_d = S_EVAL;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Advance the state and track whether the bus is held.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= S_IDLE;
            busy    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (busy_set)      busy <= 1'b1;
            else if (busy_clr) busy <= 1'b0;
        end
    end

    // R13: a pending command keeps its request and code until done
    p_cmd_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cmd_valid && !phy_done && !soft_rst) |=> (phy_cmd_valid && $stable(phy_cmd)));

    // R5: never pop an empty transmit buffer
    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_level != '0));

    // R8: never push into a full receive buffer
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_level < FULL_LVL));

    // R10: a NACK on a byte or address phase drops the stop request
    p_nack_drops_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cmd_valid && phy_done && phy_nack && phy_cmd != CMD_STOP && !ctl_wr && !soft_rst)
        |=> !c_stp);

    // R11: waiting without a kick issues nothing
    p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !kick) |=> !phy_cmd_valid);

    // R12: a START only ever goes out in master mode with 7-bit addressing
    p_start_master_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cmd_valid && phy_cmd == CMD_START) |-> (c_mst && !c_xa));

endmodule

// File: rtl/i2c_xfer_seq.sv
// Top of the I2C master transfer sequencer: register set, remaining-count
// register and FSM. Payload bytes pass straight between the buffers and the PHY.
// Assumes external transmit/receive buffers that report their levels and a
// byte-level PHY with a single-cycle done pulse.
module i2c_xfer_seq
    import i2cs_pkg::*;
#(
    parameter int BUF_DEPTH = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 10,
    parameter int TIM_W     = 8,
    localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              data_kick,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [7:0]        rx_data,
    output logic              rx_push,
    output logic              phy_cmd_valid,
    output logic [1:0]        phy_cmd,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              phy_read,
    output logic [7:0]        phy_wdata,
    input  logic              phy_done,
    input  logic              phy_nack,
    input  logic [7:0]        phy_rdata,
    output logic [TIM_W-1:0]  cfg_prescale,
    output logic [TIM_W-1:0]  cfg_scl_low,
    output logic [TIM_W-1:0]  cfg_scl_high
);

    logic             soft_rst, ctl_wr, busy;
    logic             clr_stt, clr_stp, clr_mst, set_nack, set_ardy;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [15:0]      ctl_q;
    logic [CNT_W-1:0] prog_cnt, cnt_cur;

    i2cs_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .TIM_W(TIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_cur(cnt_cur), .busy(busy),
        .clr_stt(clr_stt), .clr_stp(clr_stp), .clr_mst(clr_mst),
        .set_nack(set_nack), .set_ardy(set_ardy),
        .soft_rst(soft_rst), .ctl_wr(ctl_wr), .ctl_q(ctl_q), .prog_cnt(prog_cnt),
        .target(phy_addr), .presc(cfg_prescale), .scl_lo(cfg_scl_low), .scl_hi(cfg_scl_high)
    );

    i2cs_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .load(cnt_load), .dec(cnt_dec), .prog_cnt(prog_cnt),
        .cnt_cur(cnt_cur), .cnt_zero(cnt_zero)
    );

    i2cs_fsm #(.BUF_DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_wr(ctl_wr), .kick(data_kick),
        .c_en(ctl_q[CTL_EN]), .c_mst(ctl_q[CTL_MST]), .c_xa(ctl_q[CTL_XA]),
        .c_trx(ctl_q[CTL_TRX]), .c_rm(ctl_q[CTL_RM]), .c_stp(ctl_q[CTL_STP]),
        .c_stt(ctl_q[CTL_STT]), .cnt_zero(cnt_zero),
        .tx_level(tx_level), .rx_level(rx_level),
        .phy_done(phy_done), .phy_nack(phy_nack),
        .phy_cmd_valid(phy_cmd_valid), .phy_cmd(phy_cmd), .phy_read(phy_read),
        .tx_pop(tx_pop), .rx_push(rx_push), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .clr_stt(clr_stt), .clr_stp(clr_stp), .clr_mst(clr_mst),
        .set_nack(set_nack), .set_ardy(set_ardy), .busy(busy)
    );

    // Payload bytes pass between the buffers and the PHY without staging.
    always_comb begin
        phy_wdata = tx_data;
        rx_data   = phy_rdata;
    end

endmodule

// File: tb/sim_i2c_xfer_seq.sv
// Scoreboard bench: scenario tasks queue the expected PHY commands, and a
// monitor pops and compares them at each completed handshake.
module sim_i2c_xfer_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        data_kick = 1'b0;
    logic [2:0]  tx_level, rx_level;
    logic [7:0]  tx_data, rx_data, phy_wdata;
    logic        tx_pop, rx_push;
    logic        phy_cmd_valid, phy_read;
    logic [1:0]  phy_cmd;
    logic [9:0]  phy_addr;
    logic        phy_done = 1'b0, phy_nack = 1'b0;
    logic [7:0]  phy_rdata = '0;
    logic [7:0]  cfg_prescale, cfg_scl_low, cfg_scl_high;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_kick(data_kick),
        .tx_level(tx_level), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_level(rx_level), .rx_data(rx_data), .rx_push(rx_push),
        .phy_cmd_valid(phy_cmd_valid), .phy_cmd(phy_cmd), .phy_addr(phy_addr),
        .phy_read(phy_read), .phy_wdata(phy_wdata), .phy_done(phy_done),
        .phy_nack(phy_nack), .phy_rdata(phy_rdata), .cfg_prescale(cfg_prescale),
        .cfg_scl_low(cfg_scl_low), .cfg_scl_high(cfg_scl_high)
    );

    int n_chk = 0, n_bad = 0, withdrawn = 0;
    logic [12:0] exp_q[$];
    string       tag_q[$];

    // Bench-owned buffers
    logic [7:0] tx_mem[16];
    logic [7:0] rx_mem[16];
    int tx_head = 0, tx_tail = 0, rx_head = 0, rx_tail = 0;
    assign tx_level = 3'(tx_tail - tx_head);
    assign rx_level = 3'(rx_tail - rx_head);
    assign tx_data  = tx_mem[tx_head % 16];

    always @(posedge clk) begin
        if (tx_pop) tx_head <= tx_head + 1;
        if (rx_push) begin
            rx_mem[rx_tail % 16] <= rx_data;
            rx_tail <= rx_tail + 1;
        end
    end

    // PHY model: done two cycles after a request, with scripted NACKs.
    int   dly = 0, wr_seen = 0, rd_seen = 0, nack_wr_idx = -1;
    logic nack_start = 1'b0;
    always @(posedge clk) begin
        phy_done <= 1'b0;
        if (phy_cmd_valid && !phy_done) begin
            if (dly == 1) begin
                dly      <= 0;
                phy_done <= 1'b1;
                phy_nack <= 1'b0;
                case (phy_cmd)
                    2'd0: phy_nack <= nack_start;
                    2'd1: begin phy_nack <= (wr_seen == nack_wr_idx); wr_seen <= wr_seen + 1; end
                    2'd2: begin phy_rdata <= 8'hA0 + 8'(rd_seen); rd_seen <= rd_seen + 1; end
                    default: ;
                endcase
            end else begin
                dly <= dly + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each completed handshake with the queued expectation.
    logic pend_q = 1'b0;
    always @(negedge clk) begin
        if (pend_q && !phy_cmd_valid) withdrawn++;
        pend_q <= phy_cmd_valid && !phy_done;
        if (phy_cmd_valid && phy_done) begin
            logic [12:0] got;
            got = {phy_cmd,
                   (phy_cmd == 2'd0) ? phy_addr : (phy_cmd == 2'd1) ? {2'b0, phy_wdata} : 10'd0,
                   (phy_cmd == 2'd0) ? phy_read : 1'b0};
            if (exp_q.size() == 0) begin
                check("R12/R11/R4 unexpected command", {3'b0, got}, 16'hFFFF);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {3'b0, got}, {3'b0, e});
            end
        end
    end

    task automatic expect_cmd(input string tag, input logic [1:0] c,
                              input logic [9:0] d, input logic rd);
        exp_q.push_back({c, d, rd});
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic kick();
        @(negedge clk); data_kick = 1'b1;
        @(negedge clk); data_kick = 1'b0;
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_mem[tx_tail % 16] = b;
        tx_tail = tx_tail + 1;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] e);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        chk_reg("R2 reset control", 3'd0, 16'h0000);
        chk_reg("R2 reset status", 3'd6, 16'h0000);
        chk_reg("R2 reset count", 3'd1, 16'h0000);
        check("R13 no request after reset", {15'b0, phy_cmd_valid}, 16'h0);

        // Timing registers and control mask
        wr(3'd3, 16'h0012); wr(3'd4, 16'h0034); wr(3'd5, 16'h0056);
        check("R14 prescale out", {8'h0, cfg_prescale}, 16'h0012);
        check("R14 scl low out", {8'h0, cfg_scl_low}, 16'h0034);
        check("R14 scl high out", {8'h0, cfg_scl_high}, 16'h0056);
        chk_reg("R14 scl high readback", 3'd5, 16'h0056);
        wr(3'd0, 16'hFFFF);
        chk_reg("R1 control mask", 3'd0, 16'hCF07);
        repeat (10) @(negedge clk);
        chk_reg("R12 ten-bit start ignored", 3'd6, 16'h0000);
        wr(3'd0, 16'h0000);
        chk_reg("R2 soft reset timing", 3'd3, 16'h0000);
        chk_reg("R2 soft reset control", 3'd0, 16'h0000);

        // Master bit clear
        wr(3'd0, 16'h8001);
        repeat (10) @(negedge clk);
        chk_reg("R12 slave-mode start ignored", 3'd6, 16'h0000);

        // Counted transmit with stop
        wr(3'd2, 16'hF3A5);
        chk_reg("R3 target masked", 3'd2, 16'h03A5);
        wr(3'd1, 16'd3);
        load_tx(8'h11); load_tx(8'h22); load_tx(8'h33); load_tx(8'h44);
        expect_cmd("R3 start write", 2'd0, 10'h3A5, 1'b0);
        expect_cmd("R5 byte 1", 2'd1, 10'h011, 1'b0);
        expect_cmd("R5 byte 2", 2'd1, 10'h022, 1'b0);
        expect_cmd("R5 byte 3", 2'd1, 10'h033, 1'b0);
        expect_cmd("R6 stop", 2'd3, 10'h000, 1'b0);
        wr(3'd0, 16'h8603);
        settle();
        chk_reg("R3/R6 start and stop bits cleared", 3'd0, 16'h8600);
        chk_reg("R6 count reloaded", 3'd1, 16'd3);
        chk_reg("R6 bus released", 3'd6, 16'h0000);
        check("R5 count limits bytes", {13'b0, tx_level}, 16'd1);
        tx_tail = tx_head;

        // Counted transmit without stop, split across kicks
        wr(3'd1, 16'd5);
        load_tx(8'h01); load_tx(8'h02);
        expect_cmd("R3 start write", 2'd0, 10'h3A5, 1'b0);
        expect_cmd("R5 byte", 2'd1, 10'h001, 1'b0);
        expect_cmd("R5 byte", 2'd1, 10'h002, 1'b0);
        wr(3'd0, 16'h8601);
        settle();
        chk_reg("R5 remaining count", 3'd1, 16'd3);
        chk_reg("R5 bus held", 3'd6, 16'h0004);
        load_tx(8'h03); load_tx(8'h04);
        repeat (10) @(negedge clk);
        check("R11 no send without kick", {13'b0, tx_level}, 16'd2);
        expect_cmd("R11 byte after kick", 2'd1, 10'h003, 1'b0);
        expect_cmd("R11 byte after kick", 2'd1, 10'h004, 1'b0);
        kick();
        settle();
        chk_reg("R5 remaining count", 3'd1, 16'd1);
        load_tx(8'h05); load_tx(8'h06);
        expect_cmd("R5 last byte", 2'd1, 10'h005, 1'b0);
        kick();
        settle();
        chk_reg("R7 count exhausted", 3'd1, 16'd0);
        chk_reg("R7 access-ready", 3'd6, 16'h0006);
        chk_reg("R7 master bit cleared", 3'd0, 16'h8200);
        check("R7 no extra byte", {13'b0, tx_level}, 16'd1);
        expect_cmd("R6 stop after late request", 2'd3, 10'h000, 1'b0);
        wr(3'd0, 16'h8602);
        kick();
        settle();
        chk_reg("R6 released, ready kept", 3'd6, 16'h0002);
        chk_reg("R6 count reloaded", 3'd1, 16'd5);
        wr(3'd6, 16'h0003);
        chk_reg("R14 status cleared", 3'd6, 16'h0000);
        tx_tail = tx_head;

        // Counted receive
        wr(3'd1, 16'd6);
        expect_cmd("R3 start read", 2'd0, 10'h3A5, 1'b1);
        for (int i = 0; i < 4; i++) expect_cmd("R8 read", 2'd2, 10'h000, 1'b0);
        wr(3'd0, 16'h8403);
        settle();
        check("R8 receive buffer full", {13'b0, rx_level}, 16'd4);
        chk_reg("R8 remaining count", 3'd1, 16'd2);
        for (int i = 0; i < 4; i++)
            check("R8 received byte", {8'h0, rx_mem[(rx_head + i) % 16]}, 16'h00A0 + 16'(i));
        rx_head = rx_tail;
        expect_cmd("R8 read", 2'd2, 10'h000, 1'b0);
        expect_cmd("R8 read", 2'd2, 10'h000, 1'b0);
        expect_cmd("R6 stop", 2'd3, 10'h000, 1'b0);
        kick();
        settle();
        check("R8 fifth byte", {8'h0, rx_mem[rx_head % 16]}, 16'h00A4);
        chk_reg("R6 count reloaded", 3'd1, 16'd6);
        chk_reg("R6 bus released", 3'd6, 16'h0000);
        rx_head = rx_tail;

        // Repeat mode transmit
        wr(3'd1, 16'd1);
        load_tx(8'h71); load_tx(8'h72); load_tx(8'h73);
        expect_cmd("R9 start", 2'd0, 10'h3A5, 1'b0);
        expect_cmd("R9 byte", 2'd1, 10'h071, 1'b0);
        expect_cmd("R9 byte past count", 2'd1, 10'h072, 1'b0);
        expect_cmd("R9 byte past count", 2'd1, 10'h073, 1'b0);
        wr(3'd0, 16'h8605);
        settle();
        chk_reg("R9 count untouched", 3'd1, 16'd1);
        chk_reg("R9 bus held", 3'd6, 16'h0004);
        load_tx(8'h74); load_tx(8'h75);
        expect_cmd("R9 byte", 2'd1, 10'h074, 1'b0);
        expect_cmd("R9 byte", 2'd1, 10'h075, 1'b0);
        kick();
        settle();
        expect_cmd("R9 stop on request", 2'd3, 10'h000, 1'b0);
        wr(3'd0, 16'h8606);
        kick();
        settle();
        chk_reg("R9 released", 3'd6, 16'h0000);

        // NACK on a data byte
        nack_wr_idx = wr_seen + 1;
        wr(3'd1, 16'd4);
        load_tx(8'h81); load_tx(8'h82); load_tx(8'h83); load_tx(8'h84);
        expect_cmd("R10 start", 2'd0, 10'h3A5, 1'b0);
        expect_cmd("R10 byte", 2'd1, 10'h081, 1'b0);
        expect_cmd("R10 nacked byte", 2'd1, 10'h082, 1'b0);
        wr(3'd0, 16'h8603);
        settle();
        repeat (10) @(negedge clk);
        chk_reg("R10 nack status, bus held", 3'd6, 16'h0005);
        chk_reg("R10 stop cleared", 3'd0, 16'h8600);
        check("R10 sending stopped", {13'b0, tx_level}, 16'd2);
        wr(3'd0, 16'h0000);
        chk_reg("R2 soft reset status", 3'd6, 16'h0000);
        chk_reg("R2 soft reset count", 3'd1, 16'h0000);
        chk_reg("R2 soft reset target", 3'd2, 16'h0000);
        tx_tail = tx_head;
        nack_wr_idx = -1;

        // NACK on the address phase
        nack_start = 1'b1;
        wr(3'd2, 16'h0055);
        expect_cmd("R4 start", 2'd0, 10'h055, 1'b0);
        wr(3'd0, 16'h8603);
        settle();
        chk_reg("R4 nack, bus released", 3'd6, 16'h0001);
        chk_reg("R4 start and stop cleared", 3'd0, 16'h8600);
        kick();
        repeat (10) @(negedge clk);
        nack_start = 1'b0;

        check("R13 no request withdrawn", 16'(withdrawn), 16'd0);
        check("R13 all expected commands seen", 16'(exp_q.size()), 16'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule